// File: doc/BRIEF.md
# I2C Manual Line Override for Bus Recovery

This block lets software take direct hold of the clock and data lines of an I2C master. Bus recovery uses it, for example when a target holds the data line low and has to be clocked free. The override works only while the diagnostic bit of the mode register is set. The host then changes each line with write-only strobe offsets, and the data written is irrelevant: one offset releases the line and another pulls it low. When the diagnostic bit is clear, the engine's own line drive passes through unchanged.

The block also returns the live levels of both lines. Each line passes through a synchronizer and appears at a fixed bit of the status word. After an engine reset, the host reads the data bit this way to decide whether a recovery must run before a STOP can be issued.

Top module: `i2c_diag_lines`

## Requirements
- R1: During and after reset, both line pull-low outputs are 0 (released), and the manual state of both lines is released.
- R2: With diag_mode low, scl_pull_low and sda_pull_low equal eng_scl_low and eng_sda_low as sampled at the previous clock edge.
- R3: With diag_mode high, a bus write (bus_req=1, bus_we=1) to offset 0x2C sets the manual SCL state to pulled low, and scl_pull_low reads 1 from the second clock edge after the write.
- R4: With diag_mode high, a bus write to offset 0x24 sets the manual SCL state to released, and scl_pull_low reads 0 from the second edge after the write.
- R5: With diag_mode high, a bus write to offset 0x34 sets the manual SDA state to pulled low, and sda_pull_low reads 1 from the second edge after the write.
- R6: With diag_mode high, a bus write to offset 0x30 sets the manual SDA state to released, and sda_pull_low reads 0 from the second edge after the write.
- R7: Strobe writes made while diag_mode is low leave the manual state unchanged. The state seen after diag_mode is raised again is the state from before those writes.
- R8: Bus reads (bus_we=0) at any strobe offset, and writes to any offset other than 0x24, 0x2C, 0x30 and 0x34, leave both lines unchanged.
- R9: With diag_mode high, the engine inputs have no effect on the pull-low outputs.
- R10: Clearing diag_mode hands the lines back to the engine at the next edge and keeps the manual state. Both outputs are registered, so no combinational glitch reaches a line.
- R11: Bit 11 of stat_lines shows scl_in and bit 10 shows sda_in, each two clock edges after the pin level. Every other bit of stat_lines is 0, and the synchronizers reset to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| diag_mode | input | 1 | Diagnostic bit (bit 2) of the mode register |
| bus_req | input | 1 | Register access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte offset |
| eng_scl_low | input | 1 | Engine wants SCL pulled low |
| eng_sda_low | input | 1 | Engine wants SDA pulled low |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| scl_pull_low | output | 1 | Open-drain SCL drive, 1 = pull low |
| sda_pull_low | output | 1 | Open-drain SDA drive, 1 = pull low |
| stat_lines | output | STAT_W | Status contribution holding the synchronized line levels |

## Verification
The bench sends strobes while diag_mode is off and then turns it on. A design that gates the strobe on the wrong condition shows a line pulled low that software never asked for in diagnostic mode. It sends reads at offset 0x24, which must not act on SCL, to catch a decoder that ignores direction. Random sequences mix engine activity with diagnostic toggling, which shows up a multiplexer that lets the engine through during an override or drops the manual state on exit. The status check uses the exact two-edge delay, so a synchronizer with the wrong depth or swapped bit positions fails it.

// File: rtl/i2c_diag_pkg.sv
package i2c_diag_pkg;
  localparam int NUM_LINES = 2;
  localparam int LINE_SCL  = 0;
  localparam int LINE_SDA  = 1;

  function automatic int release_offset(int line);
    return (line == LINE_SCL) ? 32'h24 : 32'h30;
  endfunction

  function automatic int drive_offset(int line);
    return (line == LINE_SCL) ? 32'h2C : 32'h34;
  endfunction
endpackage

// File: rtl/i2c_diag_sync.sv
module i2c_diag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

  // once the chain is flushed with the input level, the output carries it
  AST_SYNC_SETTLE: assert property (@(posedge clk) disable iff (rst)
    (&(chain ~^ {STAGES{d}})) |=> (q == $past(d))); // R11
endmodule

// File: rtl/i2c_diag_line.sv
module i2c_diag_line #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REL_ADDR = '0,
  parameter logic [ADDR_W-1:0] DRV_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              diag_mode,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              eng_low,
  output logic              pull_low
);
  logic man_low;
  logic hit_rel, hit_drv;

  always_comb begin
    hit_rel = bus_req && bus_we && diag_mode && (bus_addr == REL_ADDR);
    hit_drv = bus_req && bus_we && diag_mode && (bus_addr == DRV_ADDR);
  end

  always_ff @(posedge clk) begin
    if (rst)          man_low <= 1'b0;
    else if (hit_drv) man_low <= 1'b1;
    else if (hit_rel) man_low <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) pull_low <= 1'b0;
    else     pull_low <= diag_mode ? man_low : eng_low;
  end

  AST_RST_RELEASE: assert property (@(posedge clk)
    rst |=> (!pull_low && !man_low)); // R1

  AST_ENGINE_PASS: assert property (@(posedge clk) disable iff (rst)
    !diag_mode |=> (pull_low == $past(eng_low))); // R2

  AST_DRV_STROBE: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && diag_mode && bus_addr == DRV_ADDR) |=> man_low); // R3, R5

  AST_REL_STROBE: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && diag_mode && bus_addr == REL_ADDR) |=> !man_low); // R4, R6

  AST_OFF_IGNORE: assert property (@(posedge clk) disable iff (rst)
    !diag_mode |=> $stable(man_low)); // R7

  AST_DIAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (diag_mode && !bus_req) ##1 (diag_mode && !bus_req) |=> $stable(pull_low)); // R9
endmodule

// File: rtl/i2c_diag_lines.sv
module i2c_diag_lines
  import i2c_diag_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int STAT_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int SCL_BIT     = 11,
  parameter int SDA_BIT     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              diag_mode,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              eng_scl_low,
  input  logic              eng_sda_low,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull_low,
  output logic              sda_pull_low,
  output logic [STAT_W-1:0] stat_lines
);
  localparam int LINE_BIT [NUM_LINES] = '{SCL_BIT, SDA_BIT};

  logic [NUM_LINES-1:0] eng_low_v, pull_v, pin_v, sync_v;

  assign eng_low_v = {eng_sda_low, eng_scl_low};
  assign pin_v     = {sda_in, scl_in};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    i2c_diag_line #(
      .ADDR_W  (ADDR_W),
      .REL_ADDR(ADDR_W'(release_offset(i))),
      .DRV_ADDR(ADDR_W'(drive_offset(i)))
    ) u_line (
      .clk      (clk),
      .rst      (rst),
      .diag_mode(diag_mode),
      .bus_req  (bus_req),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .eng_low  (eng_low_v[i]),
      .pull_low (pull_v[i])
    );

    i2c_diag_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk),
      .rst(rst),
      .d  (pin_v[i]),
      .q  (sync_v[i])
    );
  end

  assign scl_pull_low = pull_v[LINE_SCL];
  assign sda_pull_low = pull_v[LINE_SDA];

  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    if (b == LINE_BIT[LINE_SCL])      begin : g_scl
      assign stat_lines[b] = sync_v[LINE_SCL];
    end else if (b == LINE_BIT[LINE_SDA]) begin : g_sda
      assign stat_lines[b] = sync_v[LINE_SDA];
    end else begin : g_zero
      assign stat_lines[b] = 1'b0;
    end
  end

  // a registered handover: leaving diagnostic mode yields the engine level one edge later
  AST_HANDBACK: assert property (@(posedge clk) disable iff (rst)
    ($past(diag_mode) && !diag_mode) |=> (scl_pull_low == $past(eng_scl_low) &&
                                          sda_pull_low == $past(eng_sda_low))); // R10
endmodule

// File: tb/i2c_diag_lines_test.sv
module i2c_diag_lines_test;
  logic clk = 0;
  logic rst = 1;
  logic diag_mode = 0, bus_req = 0, bus_we = 0;
  logic [7:0] bus_addr = '0;
  logic eng_scl_low = 0, eng_sda_low = 0, scl_in = 1, sda_in = 1;
  logic scl_pull_low, sda_pull_low;
  logic [31:0] stat_lines;

  int checks = 0, errors = 0;
  bit man_scl = 0, man_sda = 0;

  always #2.5 clk = ~clk;

  i2c_diag_lines uut (
    .clk(clk), .rst(rst), .diag_mode(diag_mode), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull_low(scl_pull_low),
    .sda_pull_low(sda_pull_low), .stat_lines(stat_lines));

  function automatic bit exp_pull(bit diag, bit man, bit eng);
    return diag ? man : eng;
  endfunction

  function automatic logic [31:0] exp_stat(bit scl, bit sda);
    logic [31:0] w = '0;
    w[11] = scl;
    w[10] = sda;
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(bit we, logic [7:0] a);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a;
    if (we && diag_mode) begin
      if (a == 8'h2C) man_scl = 1;
      if (a == 8'h24) man_scl = 0;
      if (a == 8'h34) man_sda = 1;
      if (a == 8'h30) man_sda = 0;
    end
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic check_lines(string tag);
    check({tag, " scl"}, scl_pull_low, exp_pull(diag_mode, man_scl, eng_scl_low));
    check({tag, " sda"}, sda_pull_low, exp_pull(diag_mode, man_sda, eng_sda_low));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    settle(3);
    // R1: reset state
    check("R1 scl", scl_pull_low, 0);
    check("R1 sda", sda_pull_low, 0);
    check("R1 stat", stat_lines, exp_stat(1, 1));
    rst = 0;
    settle(2);

    // R2: engine passes through
    eng_scl_low = 1; settle(1);
    check("R2 scl", scl_pull_low, 1);
    eng_sda_low = 1; eng_scl_low = 0; settle(1);
    check("R2 sda", sda_pull_low, 1);
    check("R2 scl back", scl_pull_low, 0);

    // R7: strobes while diag off are ignored
    access(1, 8'h2C); access(1, 8'h34); settle(2);
    check_lines("R7 off");
    diag_mode = 1; settle(2);
    check("R7 scl kept", scl_pull_low, 0);
    check("R7 sda kept", sda_pull_low, 0);

    // R9: engine has no effect in diag mode
    eng_scl_low = 1; eng_sda_low = 1; settle(2);
    check("R9 scl", scl_pull_low, 0);
    check("R9 sda", sda_pull_low, 0);

    // R3 with exact latency: write edge then output edge
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = 8'h2C; man_scl = 1;
    @(negedge clk); bus_req = 0; bus_we = 0;
    check("R3 not yet", scl_pull_low, 0);
    @(negedge clk);
    check("R3 scl low", scl_pull_low, 1);
    // R8: read at release offset does nothing
    access(0, 8'h24); settle(2);
    check("R8 read", scl_pull_low, 1);
    access(1, 8'h28); access(1, 8'h20); settle(2);
    check("R8 other", scl_pull_low, 1);
    // R5, R6, R4
    access(1, 8'h34); settle(1);
    check("R5 sda low", sda_pull_low, 1);
    access(1, 8'h30); settle(1);
    check("R6 sda rel", sda_pull_low, 0);
    access(1, 8'h24); settle(1);
    check("R4 scl rel", scl_pull_low, 0);

    // R10: handback then manual state kept
    access(1, 8'h34);
    eng_sda_low = 0; eng_scl_low = 1;
    @(negedge clk); diag_mode = 0;
    @(negedge clk);
    check("R10 scl eng", scl_pull_low, 1);
    check("R10 sda eng", sda_pull_low, 0);
    diag_mode = 1; settle(2);
    check("R10 sda kept", sda_pull_low, 1);

    // R11: exact two-edge synchronizer delay
    @(negedge clk); scl_in = 0;
    @(negedge clk);
    check("R11 one edge", stat_lines, exp_stat(1, 1));
    @(negedge clk);
    check("R11 two edges", stat_lines, exp_stat(0, 1));
    sda_in = 0; settle(2);
    check("R11 sda", stat_lines, exp_stat(0, 0));

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] a;
      case ($urandom_range(0, 5))
        0: a = 8'h24; 1: a = 8'h2C; 2: a = 8'h30; 3: a = 8'h34;
        default: a = 8'($urandom);
      endcase
      eng_scl_low = 1'($urandom); eng_sda_low = 1'($urandom);
      scl_in = 1'($urandom); sda_in = 1'($urandom);
      if (op < 2) diag_mode = ~diag_mode;
      else if (op < 4) access(0, a);
      else access(1, a);
      settle(3);
      check_lines("R2/R3/R4/R5/R6/R7/R8/R9 rand");
      check("R11 rand", stat_lines, exp_stat(scl_in, sda_in));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule